// File: doc/BRIEF.md
# Byte-Serial AND Instruction Executor

This block executes the bitwise-AND instruction family of a 64-bit-capable variable-length CISC instruction set. Instruction bytes arrive one per cycle over a valid/ready stream. The decoder accepts optional prefixes, the opcode, a ModRM byte and an immediate of 1, 2 or 4 bytes. It then reads its operands from an internal 16-entry, 64-bit register file, forms the AND, writes the result back and updates the status flags.

All operands are registers. A memory-form ModRM byte, an opcode outside the AND family, or an immediate-group opcode whose ModRM reg field does not select AND raises a one-cycle illegal pulse and drops the instruction. A combinational read port exposes any register, and the six status flags are plain outputs, so an upstream core or a bench can observe the architectural state.

Top module: `and_byte_exec`

## Requirements
- R1: After a synchronous active-low reset, register i holds the 4-bit value 15-i repeated sixteen times (so register 0 is all ones), all flags read 0, `in_ready` is 1, and `done` and `illegal` are 0.
- R2: Register forms use ModRM bits 7:6 as mod, 5:3 as reg and 2:0 as rm. Opcodes 0x20 and 0x21 write rm with rm AND reg. Opcodes 0x22 and 0x23 write reg with reg AND rm. Even opcodes operate on 8 bits and odd opcodes on the current operand size.
- R3: The operand size defaults to 32 bits. A 0x66 prefix selects 16 bits. A REX byte (0x40 to 0x4F) with bit 3 set selects 64 bits and wins over 0x66. REX bit 2 extends the ModRM reg field and REX bit 0 extends the rm field, reaching registers 8 to 15.
- R4: For an 8-bit operand with no REX in effect, register codes 4 to 7 name bits 15:8 of registers 0 to 3. With any REX in effect, those codes name bits 7:0 of registers 4 to 7.
- R5: Opcode 0x24 ANDs an imm8 into bits 7:0 of register 0. Opcode 0x25 ANDs into register 0 a 2-byte immediate at 16-bit size, a 4-byte immediate at 32-bit size, or a 4-byte immediate sign-extended to 64 bits at 64-bit size. Immediates are little-endian.
- R6: Opcodes 0x80, 0x81 and 0x83 are AND only when ModRM reg equals 4, and they write the rm register. 0x80 is 8-bit with an imm8. 0x81 takes an immediate sized as for 0x25. 0x83 takes an imm8 sign-extended to the operand size.
- R7: A write to an 8-bit or 16-bit destination leaves all other bits of that register unchanged. A 32-bit write clears bits 63:32.
- R8: After each executed AND, CF and OF are 0. SF is the top bit of the result at operand size. ZF is 1 when that result is zero. PF is 1 when bits 7:0 of the result hold an even number of ones. AF keeps its value.
- R9: A REX byte takes effect only when it directly precedes the opcode. A 0x66 byte that follows a REX byte cancels it, and of two REX bytes the later one applies.
- R10: An unsupported opcode, a ModRM byte with mod not equal to 3, or a group opcode with reg not equal to 4 makes `illegal` high for exactly the cycle after that byte is accepted. No register or flag changes, and the next accepted byte starts a new instruction.
- R11: The final byte of an instruction is accepted at clock edge k. Registers and flags change at edge k+1. `done` is high only in the cycle after edge k+1. `in_ready` is low from edge k until `done` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction byte present |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| done | output | 1 | One-cycle pulse after write-back |
| illegal | output | 1 | One-cycle pulse on a rejected instruction |
| rd_sel | input | 4 | Register index for the observation port |
| rd_data | output | 64 | Contents of the selected register |
| flag_cf | output | 1 | Carry flag |
| flag_pf | output | 1 | Parity flag |
| flag_af | output | 1 | Adjust flag |
| flag_zf | output | 1 | Zero flag |
| flag_sf | output | 1 | Sign flag |
| flag_of | output | 1 | Overflow flag |

## Verification
Rejecting a bad instruction and accepting the first byte of the next one can happen in the same cycle, because the illegal pulse is registered while the decoder is already back in its prefix state. The bench provokes this by keeping `in_valid` high and placing the next instruction's first byte on the bus in the cycle right after every rejected opcode or ModRM byte. The pulse is checked in that cycle. The follow-on instruction's write-back must then match the arithmetic model with no trace of the aborted one. This is swept over every unsupported opcode value, every memory-form mod value and every non-AND group reg value.

// File: rtl/and_exec_pkg.sv
// Shared constants, types and opcode helpers for the AND executor.
// Assumes a 16-entry, 64-bit register file indexed by 4-bit codes.
package and_exec_pkg;

    localparam int DATA_W  = 64;
    localparam int REG_N   = 16;
    localparam int IDX_W   = $clog2(REG_N);
    localparam logic [7:0] PFX_OSZ = 8'h66;

    typedef enum logic [1:0] {
        OSZ_8,
        OSZ_16,
        OSZ_32,
        OSZ_64
    } osz_e;

    typedef struct packed {
        logic [IDX_W-1:0]  dst_idx;
        logic              dst_hi;
        logic [IDX_W-1:0]  src_idx;
        logic              src_hi;
        logic              use_imm;
        logic [DATA_W-1:0] imm;
        osz_e              osz;
    } and_uop_t;

    // Tells whether a byte is one of the supported AND opcodes.
    function automatic logic is_and_opcode(input logic [7:0] b);
        return b inside {8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25,
                         8'h80, 8'h81, 8'h83};
    endfunction

    // Number of immediate bytes an opcode carries at the given size.
    function automatic logic [2:0] imm_len(input logic [7:0] op,
                                           input logic wide,
                                           input logic half);
        case (op)
            8'h24, 8'h80, 8'h83: return 3'd1;
            8'h25, 8'h81:        return (half && !wide) ? 3'd2 : 3'd4;
            default:             return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/and_decode.sv
// Byte-serial decoder for the AND family.
// Collects prefixes, the opcode, ModRM and immediate bytes, rejects
// unsupported forms, and presents a decoded micro-op during the execute
// state. Assumes only register operands (mod = 3) are legal.
module and_decode
    import and_exec_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  logic [7:0] in_byte,
    output logic      in_ready,
    output logic      illegal,
    output logic      exec_fire,
    output logic      done_o,
    output and_uop_t  uop
);

    typedef enum logic [2:0] {
        ST_PFX,
        ST_MODRM,
        ST_IMM,
        ST_EXEC,
        ST_DONE
    } dstate_e;

    dstate_e     st;
    logic        rex_on, rex_w, rex_r, rex_b, o16;
    logic [7:0]  opc, modrm;
    logic [31:0] immb;
    logic [2:0]  icnt, ineed;
    logic        accept, wide, acc_form, reg_dst, is_byte;
    logic [IDX_W-1:0] reg_enc, rm_enc;

    assign accept = in_valid && in_ready;
    assign wide   = rex_on && rex_w;

    // Byte collection state machine and prefix capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_PFX;
            rex_on  <= 1'b0;
            rex_w   <= 1'b0;
            rex_r   <= 1'b0;
            rex_b   <= 1'b0;
            o16     <= 1'b0;
            opc     <= 8'h00;
            modrm   <= 8'h00;
            immb    <= 32'h0;
            icnt    <= 3'd0;
            ineed   <= 3'd0;
            illegal <= 1'b0;
        end else begin
            illegal <= 1'b0;
            case (st)
                ST_PFX: if (accept) begin
                    if (in_byte == PFX_OSZ) begin
                        o16    <= 1'b1;
                        rex_on <= 1'b0;
                    end else if (in_byte[7:4] == 4'h4) begin
                        rex_on <= 1'b1;
                        rex_w  <= in_byte[3];
                        rex_r  <= in_byte[2];
                        rex_b  <= in_byte[0];
                    end else if (is_and_opcode(in_byte)) begin
                        opc   <= in_byte;
                        ineed <= imm_len(in_byte, wide, o16);
                        icnt  <= 3'd0;
                        modrm <= 8'h00;
                        st    <= (in_byte[7:1] == 7'h12) ? ST_IMM : ST_MODRM;
                    end else begin
                        illegal <= 1'b1;
                        rex_on  <= 1'b0;
                        o16     <= 1'b0;
                    end
                end
                ST_MODRM: if (accept) begin
                    if (in_byte[7:6] != 2'b11 ||
                        (opc[7] && in_byte[5:3] != 3'd4)) begin
                        illegal <= 1'b1;
                        rex_on  <= 1'b0;
                        o16     <= 1'b0;
                        st      <= ST_PFX;
                    end else begin
                        modrm <= in_byte;
                        st    <= (ineed == 3'd0) ? ST_EXEC : ST_IMM;
                    end
                end
                ST_IMM: if (accept) begin
                    immb[{icnt[1:0], 3'b000} +: 8] <= in_byte;
                    icnt <= icnt + 3'd1;
                    if (icnt + 3'd1 == ineed) st <= ST_EXEC;
                end
                ST_EXEC: st <= ST_DONE;
                ST_DONE: begin
                    st     <= ST_PFX;
                    rex_on <= 1'b0;
                    o16    <= 1'b0;
                end
                default: st <= ST_PFX;
            endcase
        end
    end

    // Handshake and phase outputs derived from the state.
    always_comb begin
        in_ready  = (st == ST_PFX) || (st == ST_MODRM) || (st == ST_IMM);
        exec_fire = (st == ST_EXEC);
        done_o    = (st == ST_DONE);
    end

    // Operand-form classification of the held opcode.
    always_comb begin
        is_byte  = ~opc[0];
        acc_form = (opc[7:1] == 7'h12);
        reg_dst  = (opc[7:1] == 7'h11);
        reg_enc  = {rex_on & rex_r, modrm[5:3]};
        rm_enc   = {rex_on & rex_b, modrm[2:0]};
    end

    // Micro-op assembly: size, register mapping and immediate extension.
    always_comb begin
        logic [IDX_W-1:0] d_enc, s_enc;
        uop = '0;
        if (is_byte)    uop.osz = OSZ_8;
        else if (wide)  uop.osz = OSZ_64;
        else if (o16)   uop.osz = OSZ_16;
        else            uop.osz = OSZ_32;
        d_enc = reg_dst ? reg_enc : rm_enc;
        s_enc = reg_dst ? rm_enc  : reg_enc;
        if (acc_form) d_enc = '0;
        if (is_byte && !rex_on && d_enc[2]) begin
            uop.dst_idx = {2'b00, d_enc[1:0]};
            uop.dst_hi  = 1'b1;
        end else begin
            uop.dst_idx = d_enc;
        end
        if (is_byte && !rex_on && s_enc[2]) begin
            uop.src_idx = {2'b00, s_enc[1:0]};
            uop.src_hi  = 1'b1;
        end else begin
            uop.src_idx = s_enc;
        end
        uop.use_imm = opc[7] | acc_form;
        case (ineed)
            3'd1:    uop.imm = DATA_W'($signed(immb[7:0]));
            3'd2:    uop.imm = DATA_W'($signed(immb[15:0]));
            default: uop.imm = DATA_W'($signed(immb[31:0]));
        endcase
    end

    assert_illegal_follows_accept_R10: assert property (@(posedge clk)
        disable iff (!rst_n) illegal |-> $past(accept));

    assert_memory_form_rejected_R10: assert property (@(posedge clk)
        disable iff (!rst_n)
        (st == ST_MODRM && accept && in_byte[7:6] != 2'b11)
        |=> (illegal && st == ST_PFX));

    assert_done_single_R11: assert property (@(posedge clk)
        disable iff (!rst_n) done_o |=> !done_o);

    assert_exec_then_done_R11: assert property (@(posedge clk)
        disable iff (!rst_n) exec_fire |=> done_o);

    assert_busy_not_ready_R11: assert property (@(posedge clk)
        disable iff (!rst_n) (exec_fire || done_o) |-> !in_ready);

    assert_osz_cancels_rex_R9: assert property (@(posedge clk)
        disable iff (!rst_n)
        (st == ST_PFX && accept && in_byte == PFX_OSZ) |=> !rex_on);

endmodule

// File: rtl/and_regfile.sv
// General register file: REG_N words of DATA_W bits, one write port and
// three combinational read ports (destination, source, observation).
// Assumes each register resets to its index pattern (15-i per nibble).
module and_regfile #(
    parameter int DATA_W = 64,
    parameter int REG_N  = 16,
    parameter int IDX_W  = $clog2(REG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] rb_data,
    input  logic [IDX_W-1:0]  rc_idx,
    output logic [DATA_W-1:0] rc_data
);

    localparam int NIBS = DATA_W / 4;

    logic [DATA_W-1:0] regs [REG_N];

    for (genvar g = 0; g < REG_N; g++) begin : g_reg
        localparam logic [3:0] NIB = 4'(REG_N - 1 - g);
        logic [DATA_W-1:0] q;
        // Holds one register; loads on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= {NIBS{NIB}};
            else if (we && widx == IDX_W'(g))
                q <= wdata;
        end
        assign regs[g] = q;
    end

    // Combinational read ports.
    always_comb begin
        ra_data = regs[ra_idx];
        rb_data = regs[rb_idx];
        rc_data = regs[rc_idx];
    end

    assert_write_lands_R2: assert property (@(posedge clk)
        disable iff (!rst_n) we |=> (regs[$past(widx)] == $past(wdata)));

endmodule

// File: rtl/and_alu.sv
// Size-aware AND datapath: selects operand slices, forms the result,
// merges it into the destination word and computes SF, ZF and PF.
// Assumes DATA_W is 64 and the micro-op is stable during execute.
module and_alu
    import and_exec_pkg::*;
(
    input  and_uop_t          uop,
    input  logic [DATA_W-1:0] dst_word,
    input  logic [DATA_W-1:0] src_word,
    output logic [DATA_W-1:0] wr_word,
    output logic              res_sf,
    output logic              res_zf,
    output logic              res_pf
);

    logic [7:0]        a8, b8;
    logic [DATA_W-1:0] b_full, res;

    // Operand slice selection for byte and wider forms.
    always_comb begin
        a8     = uop.dst_hi ? dst_word[15:8] : dst_word[7:0];
        b_full = uop.use_imm ? uop.imm : src_word;
        if (uop.use_imm)     b8 = uop.imm[7:0];
        else if (uop.src_hi) b8 = src_word[15:8];
        else                 b8 = src_word[7:0];
    end

    // Result, merge into destination, and sign bit at operand size.
    always_comb begin
        res = '0;
        case (uop.osz)
            OSZ_8: begin
                res[7:0] = a8 & b8;
                wr_word  = uop.dst_hi
                         ? {dst_word[DATA_W-1:16], res[7:0], dst_word[7:0]}
                         : {dst_word[DATA_W-1:8], res[7:0]};
                res_sf   = res[7];
            end
            OSZ_16: begin
                res[15:0] = dst_word[15:0] & b_full[15:0];
                wr_word   = {dst_word[DATA_W-1:16], res[15:0]};
                res_sf    = res[15];
            end
            OSZ_32: begin
                res[31:0] = dst_word[31:0] & b_full[31:0];
                wr_word   = res;
                res_sf    = res[31];
            end
            default: begin
                res     = dst_word & b_full;
                wr_word = res;
                res_sf  = res[DATA_W-1];
            end
        endcase
        res_zf = (res == '0);
        res_pf = ~^res[7:0];
    end

endmodule

// File: rtl/and_byte_exec.sv
// Top of the byte-serial AND executor: decoder, register file, datapath
// and the status flag register. Assumes register-only operands.
module and_byte_exec
    import and_exec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    output logic        in_ready,
    output logic        done,
    output logic        illegal,
    input  logic [3:0]  rd_sel,
    output logic [63:0] rd_data,
    output logic        flag_cf,
    output logic        flag_pf,
    output logic        flag_af,
    output logic        flag_zf,
    output logic        flag_sf,
    output logic        flag_of
);

    and_uop_t          uop;
    logic              exec_fire;
    logic [DATA_W-1:0] dst_word, src_word, wr_word;
    logic              res_sf, res_zf, res_pf;

    and_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .in_ready  (in_ready),
        .illegal   (illegal),
        .exec_fire (exec_fire),
        .done_o    (done),
        .uop       (uop)
    );

    and_regfile #(
        .DATA_W (DATA_W),
        .REG_N  (REG_N),
        .IDX_W  (IDX_W)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (exec_fire),
        .widx    (uop.dst_idx),
        .wdata   (wr_word),
        .ra_idx  (uop.dst_idx),
        .ra_data (dst_word),
        .rb_idx  (uop.src_idx),
        .rb_data (src_word),
        .rc_idx  (rd_sel),
        .rc_data (rd_data)
    );

    and_alu u_alu (
        .uop      (uop),
        .dst_word (dst_word),
        .src_word (src_word),
        .wr_word  (wr_word),
        .res_sf   (res_sf),
        .res_zf   (res_zf),
        .res_pf   (res_pf)
    );

    // Status flags: cleared/set on execute, AF keeps its value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_cf <= 1'b0;
            flag_of <= 1'b0;
            flag_sf <= 1'b0;
            flag_zf <= 1'b0;
            flag_pf <= 1'b0;
            flag_af <= 1'b0;
        end else if (exec_fire) begin
            flag_cf <= 1'b0;
            flag_of <= 1'b0;
            flag_sf <= res_sf;
            flag_zf <= res_zf;
            flag_pf <= res_pf;
        end
    end

    assert_flags_cleared_R8: assert property (@(posedge clk)
        disable iff (!rst_n) exec_fire |=> (!flag_cf && !flag_of));

    assert_upper_cleared_R7: assert property (@(posedge clk)
        disable iff (!rst_n)
        (exec_fire && uop.osz == OSZ_32) |=> (dst_word[63:32] == 32'h0));

    assert_half_keeps_upper_R7: assert property (@(posedge clk)
        disable iff (!rst_n)
        (exec_fire && uop.osz == OSZ_16)
        |=> (dst_word[63:16] == $past(dst_word[63:16])));

    assert_high_byte_keeps_low_R4: assert property (@(posedge clk)
        disable iff (!rst_n)
        (exec_fire && uop.osz == OSZ_8 && uop.dst_hi)
        |=> (dst_word[7:0] == $past(dst_word[7:0])));

    assert_no_write_when_rejected_R10: assert property (@(posedge clk)
        disable iff (!rst_n) illegal |-> !exec_fire);

endmodule

// File: tb/test_and_byte_exec.sv
// Self-checking bench: sweeps register forms, immediate forms and
// rejected encodings against an arithmetic model of the requirements.
module test_and_byte_exec;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready, done, illegal;
    logic [3:0]  rd_sel = 4'd0;
    logic [63:0] rd_data;
    logic        flag_cf, flag_pf, flag_af, flag_zf, flag_sf, flag_of;

    and_byte_exec i_and_byte_exec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .done(done), .illegal(illegal),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .flag_cf(flag_cf), .flag_pf(flag_pf), .flag_af(flag_af),
        .flag_zf(flag_zf), .flag_sf(flag_sf), .flag_of(flag_of)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [63:0] m [16];
    logic [5:0]  mflg;   // {cf, pf, af, zf, sf, of}
    logic [7:0]  ib [8];
    int          nb;
    int          since_rst;
    logic [31:0] seed = 32'h1234_5678;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 16; k++) m[k] = {16{4'(15 - k)}};
        mflg = 6'b0;
        since_rst = 0;
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        model_reset();
    endtask

    task automatic add(input logic [7:0] b);
        ib[nb] = b;
        nb++;
    endtask

    function automatic logic [63:0] szmask(input int isz);
        return (isz == 8) ? '1 : ((64'd1 << (8 * isz)) - 64'd1);
    endfunction

    function automatic logic [63:0] rd_op(input logic [3:0] e, input int isz,
                                          input bit rx);
        if (isz == 1 && !rx && e[2]) return {56'h0, m[{2'b00, e[1:0]}][15:8]};
        return m[e] & szmask(isz);
    endfunction

    task automatic wr_op(input logic [3:0] e, input int isz, input bit rx,
                         input logic [63:0] r);
        if (isz == 1 && !rx && e[2]) m[{2'b00, e[1:0]}][15:8] = r[7:0];
        else if (isz == 1) m[e][7:0] = r[7:0];
        else if (isz == 2) m[e][15:0] = r[15:0];
        else if (isz == 4) m[e] = {32'h0, r[31:0]};
        else m[e] = r;
    endtask

    // Reference model of one instruction held in ib[0..nb-1].
    task automatic model_exec(output int used, output bit ill);
        bit rx = 0;
        logic [3:0] rb = 4'h0;
        bit o16 = 0;
        int p = 0;
        int isz, immn;
        logic [7:0] op, mrm;
        logic [63:0] imm, a, b, r;
        logic [3:0] renc, benc, de, se;
        while (p < nb && (ib[p] == 8'h66 || ib[p][7:4] == 4'h4)) begin
            if (ib[p] == 8'h66) begin o16 = 1; rx = 0; end
            else begin rx = 1; rb = ib[p][3:0]; end
            p++;
        end
        op = ib[p];
        p++;
        ill = !(op inside {8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25,
                           8'h80, 8'h81, 8'h83});
        used = p;
        if (ill) return;
        mrm = 8'hC0;
        if (op != 8'h24 && op != 8'h25) begin
            mrm = ib[p];
            p++;
            used = p;
            if (mrm[7:6] != 2'b11 || (op[7] && mrm[5:3] != 3'd4)) begin
                ill = 1;
                return;
            end
        end
        isz = !op[0] ? 1 : (rx && rb[3]) ? 8 : o16 ? 2 : 4;
        immn = (op == 8'h24 || op == 8'h80 || op == 8'h83) ? 1 :
               (op == 8'h25 || op == 8'h81) ? ((isz == 2) ? 2 : 4) : 0;
        imm = 64'h0;
        for (int i = 0; i < immn; i++) imm[8*i +: 8] = ib[p + i];
        if (immn > 0 && imm[8*immn - 1]) imm = imm | ~((64'd1 << (8 * immn)) - 64'd1);
        used = p + immn;
        renc = {rx & rb[2], mrm[5:3]};
        benc = {rx & rb[0], mrm[2:0]};
        de = (op == 8'h22 || op == 8'h23) ? renc :
             (op == 8'h24 || op == 8'h25) ? 4'h0 : benc;
        se = (op == 8'h22 || op == 8'h23) ? benc : renc;
        a = rd_op(de, isz, rx);
        b = op[7] || op == 8'h24 || op == 8'h25 ? imm : rd_op(se, isz, rx);
        r = a & b & szmask(isz);
        wr_op(de, isz, rx, r);
        mflg = {1'b0, ~^r[7:0], mflg[3], r == 64'h0, r[8*isz - 1], 1'b0};
    endtask

    task automatic push(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte = b;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic check_state(input string tag);
        for (int k = 0; k < 16; k++) begin
            rd_sel = 4'(k);
            #0.1;
            chk(rd_data === m[k], tag, $sformatf("reg%0d", k), rd_data, m[k]);
        end
        chk({flag_cf, flag_pf, flag_af, flag_zf, flag_sf, flag_of} === mflg,
            "R8", "flags cf,pf,af,zf,sf,of",
            {58'h0, flag_cf, flag_pf, flag_af, flag_zf, flag_sf, flag_of},
            {58'h0, mflg});
    endtask

    // Sends one instruction, checks timing and resulting state.
    task automatic run(input string tag, input bit follow);
        int used;
        bit ill;
        if (!in_valid && since_rst >= 5) do_reset();
        model_exec(used, ill);
        for (int i = 0; i < used; i++) push(ib[i]);
        since_rst++;
        if (ill) begin
            chk(illegal === 1'b1 && done === 1'b0, "R10", "illegal pulse",
                {62'h0, illegal, done}, 64'h2);
            check_state("R10");
            if (!follow) in_valid = 1'b0;
        end else begin
            in_valid = 1'b0;
            chk(done === 1'b0 && in_ready === 1'b0, "R11", "execute cycle",
                {62'h0, done, in_ready}, 64'h0);
            @(posedge clk);
            #1;
            chk(done === 1'b1 && in_ready === 1'b0 && illegal === 1'b0, "R11",
                "done cycle", {61'h0, done, in_ready, illegal}, 64'h4);
            check_state(tag);
            @(posedge clk);
            #1;
            chk(done === 1'b0 && in_ready === 1'b1, "R11", "after done",
                {62'h0, done, in_ready}, 64'h1);
        end
    endtask

    // Prefix combinations covering R3 and R9.
    task automatic add_prefix(input int ps);
        case (ps)
            1:  add(8'h66);
            2:  add(8'h40);
            3:  add(8'h41);
            4:  add(8'h44);
            5:  add(8'h45);
            6:  add(8'h48);
            7:  add(8'h4D);
            8:  add(8'h4F);
            9:  begin add(8'h66); add(8'h48); end
            10: begin add(8'h48); add(8'h66); end
            11: begin add(8'h44); add(8'h66); end
            12: add(8'h4C);
            13: begin add(8'h41); add(8'h46); end
            default: ;
        endcase
    endtask

    function automatic logic [7:0] next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed[23:16];
    endfunction

    initial begin
        repeat (180000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] ops [5];
        ops = '{8'h24, 8'h25, 8'h80, 8'h81, 8'h83};
        do_reset();
        // R1: reset state
        chk(in_ready === 1'b1 && done === 1'b0 && illegal === 1'b0, "R1",
            "handshake after reset", {61'h0, in_ready, done, illegal}, 64'h4);
        check_state("R1");

        // R2 R3 R4 R7 R9: register-register forms under every prefix set
        for (int op = 0; op < 4; op++)
            for (int ps = 0; ps < 14; ps++)
                for (int mr = 0; mr < 64; mr++) begin
                    nb = 0;
                    add_prefix(ps);
                    add(8'h20 + 8'(op));
                    add({2'b11, 6'(mr)});
                    run("R2/R3/R4/R7/R9", 1'b0);
                end

        // R5 R6: immediate forms, both immediate sign polarities
        for (int oi = 0; oi < 5; oi++)
            for (int ps = 0; ps < 14; ps++)
                for (int rm = 0; rm < ((oi < 2) ? 1 : 8); rm++)
                    for (int sv = 0; sv < 2; sv++) begin
                        nb = 0;
                        add_prefix(ps);
                        add(ops[oi]);
                        if (oi >= 2) add({2'b11, 3'd4, 3'(rm)});
                        for (int i = 0; i < 4; i++)
                            add({sv[0], next_rand()[6:0]});
                        run("R5/R6/R3/R7", 1'b0);
                    end

        // R10: every unsupported opcode, followed back-to-back by a legal one
        for (int b = 0; b < 256; b++) begin
            if (8'(b) == 8'h66 || b[7:4] == 4'h4 ||
                8'(b) inside {8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25,
                              8'h80, 8'h81, 8'h83}) continue;
            nb = 0;
            add(8'(b));
            run("R10", 1'b1);
            nb = 0;
            add(8'h48);
            add(8'h21);
            add({2'b11, 6'(b)});
            run("R10/R2", 1'b0);
        end

        // R10: memory-form ModRM on every ModRM-bearing opcode
        for (int oi = 0; oi < 7; oi++)
            for (int md = 0; md < 3; md++) begin
                logic [7:0] opv;
                opv = (oi < 4) ? 8'h20 + 8'(oi) : ops[oi - 2];
                nb = 0;
                add(8'h48);
                add(opv);
                add({2'(md), 3'd4, 3'(oi)});
                run("R10", 1'b1);
                nb = 0;
                add(8'h66);
                add(8'h83);
                add({2'b11, 3'd4, 3'(md)});
                add(8'hF0 | 8'(oi));
                run("R10/R6", 1'b0);
            end

        // R10: group opcodes whose reg field is not the AND selector
        for (int oi = 2; oi < 5; oi++)
            for (int rg = 0; rg < 8; rg++) begin
                if (rg == 4) continue;
                nb = 0;
                add(ops[oi]);
                add({2'b11, 3'(rg), 3'(7 - rg)});
                run("R10", 1'b1);
                nb = 0;
                add(8'h22);
                add({2'b11, 3'(rg), 3'(oi)});
                run("R10/R4", 1'b0);
            end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule